// File: doc/BRIEF.md
# Complementary PWM Pair with Dead-Time Insertion and Off-State Control

This block turns a single reference waveform from a PWM compare stage into two complementary pin signals, a high-side leg and a low-side leg, each with its own output-enable. When both legs are enabled, the leg that is about to switch on waits for a programmable dead time, and the leg that is switching off drops at once. This keeps the two switches of a half bridge from conducting together. The dead time is counted in ticks of a clock-enable input. Its length comes from an 8-bit code with four ranges, each range using a different tick multiplier, so short and long gaps can both be set with fine steps.

A master output enable chooses between run operation and idle operation. In run operation, a leg whose channel enable is clear is either released (output-enable low) or held at its inactive level with its output-enable high, as set by a run drive select. In idle operation, both legs are either released or forced to their programmed idle levels, as set by an idle drive select. A per-leg polarity input inverts the active level at the pin. It is applied after dead-time insertion, so inactive and idle levels are defined as pin levels.

All outputs are registered. Reset is synchronous and active high.

Top module: `pwm_comp_pair`

## Requirements
- R1: With dt_code[7] = 0, the dead time is dt_code[6:0] ticks (0 to 127).
- R2: With dt_code[7:6] = 2'b10, the dead time is (64 + dt_code[5:0]) × 2 ticks.
- R3: With dt_code[7:5] = 3'b110, the dead time is (32 + dt_code[4:0]) × 8 ticks.
- R4: With dt_code[7:5] = 3'b111, the dead time is (32 + dt_code[4:0]) × 16 ticks. The longest dead time is 1008 ticks.
- R5: With main_oe = 1 and both en_pos and en_neg set, a change of ref_in turns the leg that is switching off inactive at the second rising clock edge after the change. The leg that is switching on becomes active D ticks later, where D is the decoded dead time. With a tick every cycle this is edge 2 + D. The two legs are never active together.
- R6: If ref_in holds a level for fewer ticks than the dead time, the leg that would turn on for that level produces no pulse.
- R7: With main_oe = 1 and only one channel enable set, the enabled leg follows ref_in (active when ref_in = 1) with no dead time, two edges after the change.
- R8: With main_oe = 1 and run_drive = 0, a leg whose channel enable is clear has its output-enable at 0.
- R9: With main_oe = 1 and run_drive = 1, a leg whose channel enable is clear is driven at its inactive level (pin = its polarity bit) with output-enable 1 if either channel enable is set. If neither is set, its output-enable is 0.
- R10: With main_oe = 0 and idle_drive = 0, both output-enables are 0.
- R11: With main_oe = 0 and idle_drive = 1, both legs drive their idle level inputs with output-enable 1 when either channel enable is set, and output-enable 0 when neither is set.
- R12: For an enabled leg in run operation, pin = active state XOR polarity bit, so a polarity of 1 makes the active level low.
- R13: While rst is high, all four outputs are 0 from the first clock edge on.
- R14: The dead-time counter advances only on clock edges where dt_tick = 1. While dt_tick is held low, a pending turn-on does not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dt_tick | input | 1 | Dead-time clock enable; the counter steps on edges where it is 1 |
| ref_in | input | 1 | Reference compare waveform |
| en_pos | input | 1 | Channel enable of the high-side leg |
| en_neg | input | 1 | Channel enable of the low-side leg |
| main_oe | input | 1 | Master output enable: 1 = run, 0 = idle |
| run_drive | input | 1 | Run off-state select: 0 = release, 1 = drive inactive level |
| idle_drive | input | 1 | Idle off-state select: 0 = release, 1 = drive idle level |
| idle_lvl_pos | input | 1 | Idle pin level of the high-side leg |
| idle_lvl_neg | input | 1 | Idle pin level of the low-side leg |
| pol_pos | input | 1 | Polarity of the high-side leg (1 = active low) |
| pol_neg | input | 1 | Polarity of the low-side leg (1 = active low) |
| dt_code | input | 8 | Dead-time code |
| pin_pos | output | 1 | High-side pin level |
| oe_pos | output | 1 | High-side output-enable |
| pin_neg | output | 1 | Low-side pin level |
| oe_neg | output | 1 | Low-side output-enable |

## Verification
A wrong dead-time count, or a counter that misses its restart on a reference edge, shows up at the turn-on edge. The leg switches on one or more cycles early or late, or it emits a pulse after a reference pulse that should have been swallowed. The error is visible within the decoded dead time after the edge. A wrong off-state selection shows up at the output-enable or pin of a disabled or idle leg one cycle after the configuration is applied. A flipped polarity path shows up at the pin in that same cycle.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

  // Static configuration of one output leg
  typedef struct packed {
    logic en;        // channel enable
    logic pol;       // 1 = active-low pin
    logic idle_lvl;  // pin level in idle operation
  } leg_cfg_t;

  // Registered pin state of one leg
  typedef struct packed {
    logic pin;
    logic oe;
  } leg_out_t;

  localparam int unsigned NUM_LEGS = 2;
  localparam int unsigned LEG_POS  = 0;
  localparam int unsigned LEG_NEG  = 1;

endpackage

// File: rtl/dt_code_decoder.sv
module dt_code_decoder #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned LEN_W  = 10
) (
  input  logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  len
);
  localparam int unsigned MAX_LEN = (32 + 31) * 16;

  logic [LEN_W-1:0] base_fine;
  logic [LEN_W-1:0] base_mid;
  logic [LEN_W-1:0] base_coarse;

  always_comb begin
    base_fine   = LEN_W'(code[6:0]);
    base_mid    = LEN_W'(7'd64 + {1'b0, code[5:0]});
    base_coarse = LEN_W'(6'd32 + {1'b0, code[4:0]});
    if (!code[7])      len = base_fine;
    else if (!code[6]) len = base_mid << 1;
    else if (!code[5]) len = base_coarse << 3;
    else               len = base_coarse << 4;
  end

  // Decoded length stays within the longest range of the code
  always_comb begin
    assert_len_range_R4: assert (32'(len) <= MAX_LEN);
  end

endmodule

// File: rtl/dt_edge_timer.sv
module dt_edge_timer #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ref_in,
  input  logic             both_en,
  input  logic [LEN_W-1:0] dt_len,
  output logic             raw_pos,
  output logic             raw_neg
);
  localparam logic [LEN_W-1:0] CNT_SAT = '1;

  logic             ref_q;
  logic [LEN_W-1:0] cnt;
  logic             expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      cnt   <= '0;
    end else if (ref_in != ref_q) begin
      ref_q <= ref_in;
      cnt   <= '0;
    end else if (tick && cnt != CNT_SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt >= dt_len);

  always_comb begin
    if (both_en) begin
      raw_pos = ref_q & expired;
      raw_neg = ~ref_q & expired;
    end else begin
      raw_pos = ref_q;
      raw_neg = ref_q;
    end
  end

  // Without a tick and without a reference edge, the delayed legs hold
  assert_hold_without_tick_R14: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick) && $stable(ref_q) && $stable(dt_len) && $stable(both_en))
      |-> ($stable(raw_pos) && $stable(raw_neg)));

endmodule

// File: rtl/pin_off_state.sv
module pin_off_state
  import pwm_dt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     main_oe,
  input  logic     run_drive,
  input  logic     idle_drive,
  input  logic     any_en,
  input  leg_cfg_t cfg,
  input  logic     raw,
  output leg_out_t q
);
  leg_out_t nxt;

  always_comb begin
    if (main_oe) begin
      if (cfg.en) begin
        nxt.pin = raw ^ cfg.pol;
        nxt.oe  = 1'b1;
      end else begin
        nxt.pin = cfg.pol;
        nxt.oe  = run_drive & any_en;
      end
    end else begin
      nxt.pin = cfg.idle_lvl;
      nxt.oe  = idle_drive & any_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assert_run_release_R8: assert property (@(posedge clk) disable iff (rst)
    (main_oe && !run_drive && !cfg.en) |=> !q.oe);

  assert_run_inactive_R9: assert property (@(posedge clk) disable iff (rst)
    (main_oe && run_drive && !cfg.en && any_en) |=> (q.oe && q.pin == $past(cfg.pol)));

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (rst)
    (!main_oe && !idle_drive) |=> !q.oe);

  assert_idle_level_R11: assert property (@(posedge clk) disable iff (rst)
    (!main_oe && idle_drive && any_en) |=> (q.oe && q.pin == $past(cfg.idle_lvl)));

endmodule

// File: rtl/pwm_comp_pair.sv
module pwm_comp_pair
  import pwm_dt_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dt_tick,
  input  logic              ref_in,
  input  logic              en_pos,
  input  logic              en_neg,
  input  logic              main_oe,
  input  logic              run_drive,
  input  logic              idle_drive,
  input  logic              idle_lvl_pos,
  input  logic              idle_lvl_neg,
  input  logic              pol_pos,
  input  logic              pol_neg,
  input  logic [CODE_W-1:0] dt_code,
  output logic              pin_pos,
  output logic              oe_pos,
  output logic              pin_neg,
  output logic              oe_neg
);
  logic [LEN_W-1:0]     dt_len;
  logic [NUM_LEGS-1:0]  raw;
  leg_cfg_t             cfg   [NUM_LEGS];
  leg_out_t             legq  [NUM_LEGS];
  logic                 any_en;

  assign any_en = en_pos | en_neg;

  assign cfg[LEG_POS] = '{en: en_pos, pol: pol_pos, idle_lvl: idle_lvl_pos};
  assign cfg[LEG_NEG] = '{en: en_neg, pol: pol_neg, idle_lvl: idle_lvl_neg};

  dt_code_decoder #(.CODE_W(CODE_W), .LEN_W(LEN_W)) i_dec (
    .code (dt_code),
    .len  (dt_len)
  );

  dt_edge_timer #(.LEN_W(LEN_W)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (dt_tick),
    .ref_in  (ref_in),
    .both_en (en_pos & en_neg),
    .dt_len  (dt_len),
    .raw_pos (raw[LEG_POS]),
    .raw_neg (raw[LEG_NEG])
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    pin_off_state i_leg (
      .clk        (clk),
      .rst        (rst),
      .main_oe    (main_oe),
      .run_drive  (run_drive),
      .idle_drive (idle_drive),
      .any_en     (any_en),
      .cfg        (cfg[g]),
      .raw        (raw[g]),
      .q          (legq[g])
    );
  end

  assign pin_pos = legq[LEG_POS].pin;
  assign oe_pos  = legq[LEG_POS].oe;
  assign pin_neg = legq[LEG_NEG].pin;
  assign oe_neg  = legq[LEG_NEG].oe;

  // Both legs enabled in run operation: never active at the same time
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    (main_oe && en_pos && en_neg)
      |=> !((pin_pos ^ $past(pol_pos)) && (pin_neg ^ $past(pol_neg))));

endmodule

// File: tb/test_pwm_comp_pair.sv
module test_pwm_comp_pair;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dt_tick = 1'b1;
  logic ref_in = 1'b0;
  logic en_pos = 1'b0, en_neg = 1'b0;
  logic main_oe = 1'b0, run_drive = 1'b0, idle_drive = 1'b0;
  logic idle_lvl_pos = 1'b0, idle_lvl_neg = 1'b0;
  logic pol_pos = 1'b0, pol_neg = 1'b0;
  logic [7:0] dt_code = 8'h00;
  logic pin_pos, oe_pos, pin_neg, oe_neg;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int         at;
    logic [3:0] v;   // {pin_pos, oe_pos, pin_neg, oe_neg}
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  pwm_comp_pair i_pwm_comp_pair (
    .clk(clk), .rst(rst), .dt_tick(dt_tick), .ref_in(ref_in),
    .en_pos(en_pos), .en_neg(en_neg), .main_oe(main_oe),
    .run_drive(run_drive), .idle_drive(idle_drive),
    .idle_lvl_pos(idle_lvl_pos), .idle_lvl_neg(idle_lvl_neg),
    .pol_pos(pol_pos), .pol_neg(pol_neg), .dt_code(dt_code),
    .pin_pos(pin_pos), .oe_pos(oe_pos), .pin_neg(pin_neg), .oe_neg(oe_neg)
  );

  // Monitor: pop and compare expected items in their cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      exp_t e;
      logic [3:0] act;
      e = sb_q.pop_front();
      act = {pin_pos, oe_pos, pin_neg, oe_neg};
      checks++;
      if (e.at != cyc) begin
        errors++;
        $display("FAIL %s: item for cycle %0d missed (now %0d), act=%b exp=%b",
                 e.tag, e.at, cyc, act, e.v);
      end else if (act !== e.v) begin
        errors++;
        $display("FAIL %s: cycle %0d act=%b exp=%b", e.tag, cyc, act, e.v);
      end
    end
  end

  task automatic expect_at(int at, logic [3:0] v, string tag);
    sb_q.push_back('{at, v, tag});
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Call right after applying inputs at a falling edge
  task automatic settle_expect(int lat, logic [3:0] v, string tag);
    expect_at(cyc + lat, v, tag);
    expect_at(cyc + lat + 2, v, tag);
    step(lat + 3);
  endtask

  // Reference edge with both legs enabled, positive polarity, tick every cycle
  task automatic dt_edge(logic lvl, int n, string tag);
    logic [3:0] on_v;
    on_v = lvl ? 4'b1101 : 4'b0111;
    ref_in = lvl;
    if (n == 0) begin
      expect_at(cyc + 2, on_v, tag);
    end else begin
      expect_at(cyc + 2, 4'b0101, tag);
      expect_at(cyc + 1 + n, 4'b0101, tag);
      expect_at(cyc + 2 + n, on_v, tag);
    end
    step(n + 4);
  endtask

  task automatic code_pair(logic [7:0] code, int n, string tag);
    dt_code = code;
    step(2);
    dt_edge(1'b1, n, tag);
    dt_edge(1'b0, n, tag);
  endtask

  initial begin
    step(1);
    expect_at(cyc + 1, 4'b0000, "R13");   // reset state
    expect_at(cyc + 2, 4'b0000, "R13");
    step(3);
    rst = 1'b0;
    step(1);

    // Idle operation
    en_pos = 1'b1; en_neg = 1'b1; idle_lvl_pos = 1'b1; idle_lvl_neg = 1'b0;
    settle_expect(1, 4'b1000, "R10");
    idle_drive = 1'b1;
    settle_expect(1, 4'b1101, "R11");
    en_pos = 1'b0; en_neg = 1'b0;
    settle_expect(1, 4'b1000, "R11");

    // Run operation, complementary with dead time
    idle_drive = 1'b0; en_pos = 1'b1; en_neg = 1'b1; main_oe = 1'b1;
    settle_expect(1, 4'b0111, "R5");
    code_pair(8'h00, 0,    "R1");
    code_pair(8'h05, 5,    "R1");
    code_pair(8'h7F, 127,  "R1");
    code_pair(8'h80, 128,  "R2");
    code_pair(8'hBF, 254,  "R2");
    code_pair(8'hC2, 272,  "R3");
    code_pair(8'hE1, 528,  "R4");
    code_pair(8'hFF, 1008, "R4");

    // R6: pulse of 4 cycles against 10-tick dead time
    dt_code = 8'h0A;
    step(12);
    begin
      int c;
      c = cyc;
      ref_in = 1'b1;
      expect_at(c + 2,  4'b0101, "R6");
      expect_at(c + 12, 4'b0101, "R6");
      expect_at(c + 13, 4'b0101, "R6");
      expect_at(c + 15, 4'b0101, "R6");
      expect_at(c + 16, 4'b0111, "R6");
      step(4);
      ref_in = 1'b0;
      step(20);
    end

    // R14: no ticks, no turn-on; ticks resume, turn-on after 4 more edges
    dt_code = 8'h04;
    dt_tick = 1'b0;
    ref_in = 1'b1;
    expect_at(cyc + 2,  4'b0101, "R14");
    expect_at(cyc + 20, 4'b0101, "R14");
    step(25);
    dt_tick = 1'b1;
    expect_at(cyc + 4, 4'b0101, "R14");
    expect_at(cyc + 5, 4'b1101, "R14");
    step(8);
    dt_edge(1'b0, 4, "R14");

    // R12: polarity at the pin
    dt_code = 8'h00; pol_pos = 1'b1; pol_neg = 1'b1;
    settle_expect(1, 4'b1101, "R12");
    ref_in = 1'b1;
    settle_expect(2, 4'b0111, "R12");
    pol_pos = 1'b0; pol_neg = 1'b0;
    settle_expect(1, 4'b1101, "R12");

    // Single enabled leg, disabled leg released
    en_neg = 1'b0; run_drive = 1'b0;
    settle_expect(1, 4'b1100, "R8");
    ref_in = 1'b0;
    settle_expect(2, 4'b0100, "R7");
    en_pos = 1'b0; en_neg = 1'b1;
    settle_expect(1, 4'b0001, "R8");
    ref_in = 1'b1;
    settle_expect(2, 4'b0011, "R7");

    // Disabled leg driven at inactive level
    run_drive = 1'b1; pol_pos = 1'b1;
    settle_expect(1, 4'b1111, "R9");
    en_neg = 1'b0;
    settle_expect(1, 4'b1000, "R9");

    step(5);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule